// File: doc/BRIEF.md
# Audio/Video Crossbar Select and Status Decoder

This block is the digital control core of a five-source, two-sink video and stereo-audio switch. Two 8-bit configuration bytes, committed together by a write strobe, are turned into registered one-hot select lines. Each one-hot line drives one analog switch leg. Sink 1 has independent video and audio selectors, an audio attenuation control, and a choice between separate luma/chroma pass-through and a loop path from an external luma/chroma separator. Sink 2 uses one selector that steers its video and its audio together. The block also produces a two-signal drive control for a DC signalling level.

On the sensing side, digital comparator results for the three luma/chroma-capable sources are registered into two status bytes. The first status byte holds a presence flag per separate-video connector. The second holds a 2-bit aspect-ratio code per source. An external mute pin silences every audio leg and leaves video unaffected.

Source numbering: index 0 is the tuner source and indices 1 to 4 are the auxiliary sources. Only indices 1 to 3 carry a separate luma/chroma pair.

Top module: `av_xbar_ctrl`

## Requirements
- R1: Byte A bits [2:0] select sink-1 composite video. Codes 1 to 5 set bit (code−1) of `v1_cv_oh`. Codes 0, 6 and 7 leave it all zero.
- R2: Byte A bits [5:3] select sink-1 audio on `a1_oh` with the same code map as R1, independently of the video code.
- R3: Byte B bits [2:0] drive both `v2_cv_oh` and `a2_oh` with the R1 code map, so with mute released both always match.
- R4: The separate-video flag is byte A bit 6 for sink 1 and byte B bit 3 for sink 2. When the flag is 1, codes 2 to 4 set bit (code−2) of the sink's luma/chroma one-hot. Codes 1 and 5 and the mute codes leave it zero, because sources 0 and 4 have no pair.
- R5: `v1_yc_loop` is 1 exactly when byte A bit 6 is 0 and the sink-1 video code is in 1 to 5. It is never set together with a bit of `v1_yc_oh`.
- R6: Byte A bit 7 drives `a1_att` (1 = −6 dB on sink-1 audio). Sink 2 has no such control.
- R7: Byte B bits [5:4] form the DC code. Code 1 asserts `dc_pull_lo`, code 2 asserts `dc_mid`, and codes 0 and 3 assert neither. The two are never high together.
- R8: While `mute_pin` is sampled high, `a1_oh` and `a2_oh` are zero on the next edge. Video and luma/chroma outputs keep their values.
- R9: A write sampled at edge k loads both bytes. The select outputs change at edge k+1. Without a write they hold.
- R10: `stat_a` bit i is the registered value of `s_lo[i]` (connector present), one edge after sampling. Bits [7:3] read 0.
- R11: `stat_b` bits [2i+1:2i] give the aspect code for source i+1, one edge after sampling. If `s_open[i]` is set the code is 3. Otherwise `gt_hi[i]` gives 2, `gt_lo[i]` gives 1, and neither gives 0. Bits [7:6] read 0.
- R12: During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Commit strobe for both bytes |
| cfg_a | input | 8 | Sink-1 configuration byte |
| cfg_b | input | 8 | Sink-2 and DC configuration byte |
| mute_pin | input | 1 | External audio mute |
| s_lo | input | 3 | Connector-present comparator per capable source |
| s_open | input | 3 | Connector-open detect per capable source |
| gt_lo | input | 3 | Aspect level above low threshold |
| gt_hi | input | 3 | Aspect level above high threshold |
| v1_cv_oh | output | 5 | Sink-1 composite source one-hot |
| v1_yc_oh | output | 3 | Sink-1 luma/chroma source one-hot |
| v1_yc_loop | output | 1 | Sink-1 luma/chroma from separator loop |
| a1_oh | output | 5 | Sink-1 audio source one-hot |
| a1_att | output | 1 | Sink-1 audio −6 dB |
| v2_cv_oh | output | 5 | Sink-2 composite source one-hot |
| v2_yc_oh | output | 3 | Sink-2 luma/chroma source one-hot |
| a2_oh | output | 5 | Sink-2 audio source one-hot |
| dc_pull_lo | output | 1 | DC level pulled to ground |
| dc_mid | output | 1 | DC level at mid voltage |
| stat_a | output | 8 | Connector-present status byte |
| stat_b | output | 8 | Aspect status byte |

## Verification
A wrongly stored configuration byte appears at the select ports exactly one edge after the commit, as the wrong one-hot bit or a missing mute. That edge is also where the bench looks, and it checks again on the cycle in between that the outputs have not moved early. A decode error for a single code value is exposed because every byte value is swept for both bytes. A mis-prioritised aspect comparator shows up in `stat_b` one edge after the comparator pattern is applied, since all comparator combinations are swept.

// File: rtl/av_xbar_pkg.sv
package av_xbar_pkg;

   localparam int SEL_W = 3;

   typedef struct packed {
      logic             att;
      logic             ys;
      logic [SEL_W-1:0] aud;
      logic [SEL_W-1:0] vid;
   } cfg_a_t;

   typedef struct packed {
      logic [1:0]       spare;
      logic [1:0]       dc;
      logic             ys;
      logic [SEL_W-1:0] sel;
   } cfg_b_t;

   typedef enum logic [1:0] {
      DC_HIGH_A = 2'd0,
      DC_GND    = 2'd1,
      DC_MIDV   = 2'd2,
      DC_HIGH_B = 2'd3
   } dc_code_e;

   typedef enum logic [1:0] {
      ASP_NARROW = 2'd0,
      ASP_BOX    = 2'd1,
      ASP_WIDE   = 2'd2,
      ASP_ABSENT = 2'd3
   } asp_code_e;

endpackage

// File: rtl/av_sel_decode.sv
module av_sel_decode #(
   parameter int N_SRC = 5,
   parameter int N_SC  = 3,
   parameter int SEL_W = 3
) (
   input  logic [SEL_W-1:0] code,
   input  logic             ys,
   output logic [N_SRC-1:0] cv_oh,
   output logic [N_SC-1:0]  yc_oh,
   output logic             valid
);

   if (N_SRC > (1 << SEL_W) - 1) begin : g_bad_src
      $error("av_sel_decode: N_SRC does not fit the code width");
   end
   if (N_SC > N_SRC - 2) begin : g_bad_sc
      $error("av_sel_decode: capable sources must leave tuner and last source");
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_cv
      assign cv_oh[i] = (code == SEL_W'(i + 1));
   end

   for (genvar j = 0; j < N_SC; j++) begin : g_yc
      assign yc_oh[j] = ys && (code == SEL_W'(j + 2));
   end

   assign valid = (code != '0) && (code <= SEL_W'(N_SRC));

endmodule

// File: rtl/av_status_enc.sv
module av_status_enc
   import av_xbar_pkg::*;
#(
   parameter int N_SC = 3
) (
   input  logic [N_SC-1:0]   s_lo,
   input  logic [N_SC-1:0]   s_open,
   input  logic [N_SC-1:0]   gt_lo,
   input  logic [N_SC-1:0]   gt_hi,
   output logic [N_SC-1:0]   present,
   output logic [2*N_SC-1:0] asp_flat
);

   for (genvar i = 0; i < N_SC; i++) begin : g_ch
      asp_code_e code;
      always_comb begin
         if (s_open[i])      code = ASP_ABSENT;
         else if (gt_hi[i])  code = ASP_WIDE;
         else if (gt_lo[i])  code = ASP_BOX;
         else                code = ASP_NARROW;
      end
      assign asp_flat[2*i +: 2] = code;
      assign present[i]         = s_lo[i];
   end

endmodule

// File: rtl/av_dc_drive.sv
module av_dc_drive
   import av_xbar_pkg::*;
(
   input  logic [1:0] dc,
   output logic       pull_lo,
   output logic       mid
);

   always_comb begin
      pull_lo = 1'b0;
      mid     = 1'b0;
      case (dc_code_e'(dc))
         DC_GND:  pull_lo = 1'b1;
         DC_MIDV: mid     = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/av_xbar_ctrl.sv
module av_xbar_ctrl
   import av_xbar_pkg::*;
#(
   parameter int N_SRC = 5,
   parameter int N_SC  = 3,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [BYTE_W-1:0] cfg_a,
   input  logic [BYTE_W-1:0] cfg_b,
   input  logic              mute_pin,
   input  logic [N_SC-1:0]   s_lo,
   input  logic [N_SC-1:0]   s_open,
   input  logic [N_SC-1:0]   gt_lo,
   input  logic [N_SC-1:0]   gt_hi,
   output logic [N_SRC-1:0]  v1_cv_oh,
   output logic [N_SC-1:0]   v1_yc_oh,
   output logic              v1_yc_loop,
   output logic [N_SRC-1:0]  a1_oh,
   output logic              a1_att,
   output logic [N_SRC-1:0]  v2_cv_oh,
   output logic [N_SC-1:0]   v2_yc_oh,
   output logic [N_SRC-1:0]  a2_oh,
   output logic              dc_pull_lo,
   output logic              dc_mid,
   output logic [BYTE_W-1:0] stat_a,
   output logic [BYTE_W-1:0] stat_b
);

   localparam int ASP_W = 2 * N_SC;

   if (BYTE_W != $bits(cfg_a_t)) begin : g_bad_byte
      $error("av_xbar_ctrl: byte width must match the configuration layout");
   end
   if (ASP_W > BYTE_W) begin : g_bad_stat
      $error("av_xbar_ctrl: aspect status does not fit one byte");
   end

   cfg_a_t ca_q;
   cfg_b_t cb_q;
   logic   unused_spare;
   assign unused_spare = ^cb_q.spare;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ca_q <= '0;
         cb_q <= '0;
      end else if (cfg_wr) begin
         ca_q <= cfg_a_t'(cfg_a);
         cb_q <= cfg_b_t'(cfg_b);
      end
   end

   logic [N_SRC-1:0] v1_cv_d, a1_d, v2_cv_d, a1_unused_cv;
   logic [N_SC-1:0]  v1_yc_d, v2_yc_d, a1_unused_yc;
   logic             v1_ok, a1_ok, v2_ok;
   logic             unused_dec;
   assign unused_dec = ^{a1_unused_yc, a1_ok, v2_ok};

   av_sel_decode #(.N_SRC(N_SRC), .N_SC(N_SC), .SEL_W(SEL_W)) u_dec_v1 (
      .code(ca_q.vid), .ys(ca_q.ys), .cv_oh(v1_cv_d), .yc_oh(v1_yc_d), .valid(v1_ok));

   av_sel_decode #(.N_SRC(N_SRC), .N_SC(N_SC), .SEL_W(SEL_W)) u_dec_a1 (
      .code(ca_q.aud), .ys(1'b0), .cv_oh(a1_d), .yc_oh(a1_unused_yc), .valid(a1_ok));

   av_sel_decode #(.N_SRC(N_SRC), .N_SC(N_SC), .SEL_W(SEL_W)) u_dec_o2 (
      .code(cb_q.sel), .ys(cb_q.ys), .cv_oh(v2_cv_d), .yc_oh(v2_yc_d), .valid(v2_ok));

   assign a1_unused_cv = '0;

   logic dc_lo_d, dc_mid_d;
   av_dc_drive u_dc (.dc(cb_q.dc), .pull_lo(dc_lo_d), .mid(dc_mid_d));

   logic [N_SC-1:0]  pres_d;
   logic [ASP_W-1:0] asp_d;
   av_status_enc #(.N_SC(N_SC)) u_stat (
      .s_lo(s_lo), .s_open(s_open), .gt_lo(gt_lo), .gt_hi(gt_hi),
      .present(pres_d), .asp_flat(asp_d));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1_cv_oh   <= '0;
         v1_yc_oh   <= '0;
         v1_yc_loop <= 1'b0;
         a1_oh      <= '0;
         a1_att     <= 1'b0;
         v2_cv_oh   <= '0;
         v2_yc_oh   <= '0;
         a2_oh      <= '0;
         dc_pull_lo <= 1'b0;
         dc_mid     <= 1'b0;
         stat_a     <= '0;
         stat_b     <= '0;
      end else begin
         v1_cv_oh   <= v1_cv_d;
         v1_yc_oh   <= v1_yc_d;
         v1_yc_loop <= v1_ok && !ca_q.ys;
         a1_oh      <= mute_pin ? a1_unused_cv : a1_d;
         a1_att     <= ca_q.att;
         v2_cv_oh   <= v2_cv_d;
         v2_yc_oh   <= v2_yc_d;
         a2_oh      <= mute_pin ? '0 : v2_cv_d;
         dc_pull_lo <= dc_lo_d;
         dc_mid     <= dc_mid_d;
         stat_a     <= BYTE_W'(pres_d);
         stat_b     <= BYTE_W'(asp_d);
      end
   end

   AST_V1_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(v1_cv_oh) && $onehot0(a1_oh)); // R1

   AST_O2_TIED: assert property (@(posedge clk) disable iff (!rst_n)
      !mute_pin |=> (a2_oh == v2_cv_oh)); // R3

   AST_YC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({v1_yc_oh, v1_yc_loop})); // R5

   AST_DC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(dc_pull_lo && dc_mid)); // R7

   AST_AUDIO_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
      mute_pin |=> (a1_oh == '0 && a2_oh == '0)); // R8

   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr ##1 !cfg_wr) |=> ($stable(v1_cv_oh) && $stable(v2_cv_oh))); // R9

   for (genvar i = 0; i < N_SC; i++) begin : g_stat_chk
      AST_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
         s_lo[i] |=> stat_a[i]); // R10
      AST_OPEN_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
         s_open[i] |=> (stat_b[2*i +: 2] == 2'd3)); // R11
   end

endmodule

// File: tb/sim_av_xbar_ctrl.sv
`timescale 1ns/1ps
module sim_av_xbar_ctrl;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, cfg_wr, mute_pin;
   logic [7:0] cfg_a, cfg_b;
   logic [2:0] s_lo, s_open, gt_lo, gt_hi;
   logic [4:0] v1_cv_oh, a1_oh, v2_cv_oh, a2_oh;
   logic [2:0] v1_yc_oh, v2_yc_oh;
   logic       v1_yc_loop, a1_att, dc_pull_lo, dc_mid;
   logic [7:0] stat_a, stat_b;

   av_xbar_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_a(cfg_a), .cfg_b(cfg_b),
      .mute_pin(mute_pin), .s_lo(s_lo), .s_open(s_open), .gt_lo(gt_lo), .gt_hi(gt_hi),
      .v1_cv_oh(v1_cv_oh), .v1_yc_oh(v1_yc_oh), .v1_yc_loop(v1_yc_loop),
      .a1_oh(a1_oh), .a1_att(a1_att), .v2_cv_oh(v2_cv_oh), .v2_yc_oh(v2_yc_oh),
      .a2_oh(a2_oh), .dc_pull_lo(dc_pull_lo), .dc_mid(dc_mid),
      .stat_a(stat_a), .stat_b(stat_b));

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] e_oh(input logic [2:0] c);
      return (c >= 3'd1 && c <= 3'd5) ? 5'(5'd1 << (c - 3'd1)) : 5'd0;
   endfunction

   function automatic logic [2:0] e_yc(input logic f, input logic [2:0] c);
      return (f && c >= 3'd2 && c <= 3'd4) ? 3'(3'd1 << (c - 3'd2)) : 3'd0;
   endfunction

   function automatic logic [1:0] e_asp(input logic op, input logic hi, input logic lo);
      if (op) return 2'd3;
      if (hi) return 2'd2;
      if (lo) return 2'd1;
      return 2'd0;
   endfunction

   task automatic check_cfg(input logic [7:0] a, input logic [7:0] b, input string tag);
      chk({"R1 ", tag}, v1_cv_oh, e_oh(a[2:0]));
      chk({"R2 ", tag}, a1_oh, e_oh(a[5:3]));
      chk({"R3 ", tag}, {a2_oh, v2_cv_oh}, {e_oh(b[2:0]), e_oh(b[2:0])});
      chk({"R4 ", tag}, {v1_yc_oh, v2_yc_oh}, {e_yc(a[6], a[2:0]), e_yc(b[3], b[2:0])});
      chk({"R5 ", tag}, v1_yc_loop, !a[6] && a[2:0] >= 3'd1 && a[2:0] <= 3'd5);
      chk({"R6 ", tag}, a1_att, a[7]);
      chk({"R7 ", tag}, {dc_pull_lo, dc_mid}, {b[5:4] == 2'd1, b[5:4] == 2'd2});
   endtask

   logic [7:0] prev_a = 8'h00, prev_b = 8'h00;

   task automatic write_and_check(input logic [7:0] a, input logic [7:0] b);
      @(negedge clk);
      cfg_a = a; cfg_b = b; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      check_cfg(prev_a, prev_b, "R9 stale before update");
      @(negedge clk);
      check_cfg(a, b, "after commit");
      prev_a = a; prev_b = b;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_wr = 1'b0; mute_pin = 1'b0; cfg_a = 8'hFF; cfg_b = 8'hFF;
      s_lo = 3'b111; s_open = 3'b111; gt_lo = 3'b111; gt_hi = 3'b111;
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12 selects", {v1_cv_oh, v1_yc_oh, v1_yc_loop, a1_oh, a1_att}, 0);
      chk("R12 sink2", {v2_cv_oh, v2_yc_oh, a2_oh, dc_pull_lo, dc_mid}, 0);
      chk("R12 status", {stat_a, stat_b}, 0);
      s_lo = 0; s_open = 0; gt_lo = 0; gt_hi = 0; cfg_a = 0; cfg_b = 0;
      rst_n = 1'b1;
      @(negedge clk);

      for (int a = 0; a < 256; a++) write_and_check(8'(a), 8'h1B);
      for (int b = 0; b < 256; b++) write_and_check(8'h53, 8'(b));

      // R9: no write means no change
      @(negedge clk);
      cfg_a = 8'h00; cfg_b = 8'h00;
      repeat (3) @(negedge clk);
      check_cfg(prev_a, prev_b, "R9 hold without write");

      // R8: mute pin
      write_and_check(8'h62, 8'h23);
      mute_pin = 1'b1;
      @(negedge clk);
      chk("R8 audio muted", {a1_oh, a2_oh}, 0);
      chk("R8 video kept", {v1_cv_oh, v2_cv_oh, v1_yc_oh, v2_yc_oh},
          {e_oh(3'd2), e_oh(3'd3), e_yc(1'b1, 3'd2), e_yc(1'b0, 3'd3)});
      mute_pin = 1'b0;
      @(negedge clk);
      chk("R8 audio restored", {a1_oh, a2_oh}, {e_oh(3'd4), e_oh(3'd3)});

      // R10 R11: sweep every comparator combination
      for (int p = 0; p < 4096; p++) begin
         logic [11:0] v;
         logic [7:0]  ea, eb;
         v = 12'(p);
         s_lo = v[2:0]; s_open = v[5:3]; gt_lo = v[8:6]; gt_hi = v[11:9];
         ea = {5'd0, v[2:0]};
         eb = 8'd0;
         for (int i = 0; i < 3; i++) eb[2*i +: 2] = e_asp(v[3+i], v[9+i], v[6+i]);
         @(negedge clk);
         chk("R10 present status", stat_a, ea);
         chk("R11 aspect status", stat_b, eb);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule